// File: doc/BRIEF.md
# Parallel Camera Sensor Capture

This block takes pixel words from an image sensor over a parallel bus. The bus carries a pixel clock, a vertical sync, an optional horizontal sync and a data word, 20 bits wide by default. The block runs entirely in the sensor's pixel clock domain. It samples the bus on a selectable pixel clock edge, finds frame boundaries from the vertical sync, and decides which samples carry pixels. Each accepted word goes into a small show-ahead FIFO, tagged with a start-of-frame flag and, in gated mode, an end-of-line flag.

Two capture modes are supported. In gated mode, horizontal sync qualifies the data. In non-gated mode, horizontal sync is ignored and every sample inside a frame is a pixel. In non-gated mode the sensor may stop the pixel clock between lines, so the block holds no state that depends on a free-running clock. Sync polarities and the sampling edge are set by static configuration inputs. These inputs are copied into the working settings only while no frame is in progress, so one frame is always captured under a single set of settings.

Top module: `csi_capture`

## Requirements
- R1: In gated mode (`cfg_nongated`=0), a sample is stored only when a frame is in progress, vertical sync is still at its active level and horizontal sync is at its active level. All other samples are dropped.
- R2: In non-gated mode (`cfg_nongated`=1), every sample taken while a frame is in progress and vertical sync is active is stored, whatever the value of horizontal sync.
- R3: A frame starts on a vertical sync transition: rising when `cfg_vs_fall`=0, falling when `cfg_vs_fall`=1. The sample that shows the transition carries no pixel. The frame ends at the first sample where vertical sync is back at its idle level, and that sample is not stored.
- R4: Horizontal sync is active high when `cfg_hs_low`=0 and active low when `cfg_hs_low`=1.
- R5: All bus inputs are sampled on the rising pixel clock edge when `cfg_pclk_fall`=0 and on the falling edge when `cfg_pclk_fall`=1.
- R6: `out_sof` is 1 on the first stored word of each frame and 0 on every other word.
- R7: In gated mode, `out_eol` is 1 on the last word of each run of stored samples, that is, when the next sample is not stored. In non-gated mode, `out_eol` is always 0.
- R8: A word that arrives while the FIFO holds DEPTH (8) words is dropped and `overflow` is set. `overflow` stays 1 until the next frame start clears it.
- R9: Configuration changes made while a frame is in progress have no effect until the frame has ended.
- R10: After reset, and while `enable` is 0, no frame can start. A frame already in progress when `enable` is released is not captured; capture begins only at the next valid start transition.
- R11: The FIFO returns words in arrival order. `out_valid` shows that a word is present at the head, and `rd_en` together with `out_valid` removes that word at the next pixel clock edge. After reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Sensor pixel clock; every register runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Capture enable; when 0, the frame tracker is cleared |
| cfg_nongated | input | 1 | 1 selects non-gated mode, 0 selects gated mode |
| cfg_hs_low | input | 1 | 1 selects active-low horizontal sync |
| cfg_vs_fall | input | 1 | 1 selects a falling vertical sync edge as frame start |
| cfg_pclk_fall | input | 1 | 1 selects sampling on the falling pixel clock edge |
| sen_vsync | input | 1 | Sensor vertical sync |
| sen_hsync | input | 1 | Sensor horizontal sync |
| sen_data | input | DW | Sensor pixel data |
| rd_en | input | 1 | Pop request for the FIFO head |
| out_valid | output | 1 | FIFO holds at least one word |
| out_data | output | DW | Pixel data at the FIFO head |
| out_sof | output | 1 | Start-of-frame flag of the head word |
| out_eol | output | 1 | End-of-line flag of the head word |
| overflow | output | 1 | Sticky flag: a word was dropped because the FIFO was full |

## Verification
A sample taken on clock edge k is written to the FIFO at edge k+1 in non-gated mode. In gated mode it is written at edge k+2, because the word waits one sample to learn its end-of-line flag. It then shows at the FIFO head right after that edge. The checks do not wait a fixed number of cycles. A monitor compares every popped word, at the falling edge, against an ordered list of expected words. After each frame, the bench drives enough idle samples to cover the longest path before it compares the number of words received. Single-bit results such as `overflow` and `out_valid` are read between edges, several idle samples after the stimulus that causes them.

// File: rtl/csi_pkg.sv
package csi_pkg;

  typedef struct packed {
    logic nongated;
    logic hs_low;
    logic vs_fall;
    logic pclk_fall;
  } csi_cfg_t;

endpackage

// File: rtl/csi_sampler.sv
module csi_sampler #(
  parameter int DW = 20
) (
  input  logic          pclk,
  input  logic          rst_n,
  input  logic          edge_fall,
  input  logic          vs_i,
  input  logic          hs_i,
  input  logic [DW-1:0] d_i,
  output logic          vs_o,
  output logic          hs_o,
  output logic [DW-1:0] d_o
);

  localparam int SW = DW + 2;

  logic [SW-1:0] rise_q;
  logic [SW-1:0] fall_q;
  logic [SW-1:0] sel;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= {vs_i, hs_i, d_i};
  end

  always_ff @(negedge pclk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= {vs_i, hs_i, d_i};
  end

  always_comb begin
    sel = edge_fall ? fall_q : rise_q;
    vs_o = sel[SW-1];
    hs_o = sel[SW-2];
    d_o  = sel[DW-1:0];
  end

endmodule

// File: rtl/csi_framer.sv
module csi_framer
  import csi_pkg::*;
#(
  parameter int DW = 20
) (
  input  logic          pclk,
  input  logic          rst_n,
  input  logic          enable,
  input  csi_cfg_t      cfg_in,
  input  logic          vs,
  input  logic          hs,
  input  logic [DW-1:0] d,
  input  logic          fifo_full,
  output csi_cfg_t      eff_cfg,
  output logic          wr_req,
  output logic [DW+1:0] wr_word,
  output logic          overflow
);

  logic          seen_q, seen_d;
  logic          vs_prev_q, vs_prev_d;
  logic          in_frame_q, in_frame_d;
  csi_cfg_t      act_q, act_d;
  logic          sof_pend_q, sof_pend_d;
  logic          stg_vld_q, stg_vld_d;
  logic          stg_sof_q;
  logic [DW-1:0] stg_d_q;
  logic          ovf_q, ovf_d;

  logic vs_edge, sof, vs_act, hs_act, cap, ld_stage;

  always_comb begin
    eff_cfg  = in_frame_q ? act_q : cfg_in;
    vs_edge  = eff_cfg.vs_fall ? (!vs && vs_prev_q) : (vs && !vs_prev_q);
    sof      = enable && seen_q && !in_frame_q && vs_edge;
    vs_act   = vs ^ eff_cfg.vs_fall;
    hs_act   = hs ^ eff_cfg.hs_low;
    cap      = enable && in_frame_q && vs_act && (eff_cfg.nongated || hs_act);
    ld_stage = cap && !eff_cfg.nongated;

    if (eff_cfg.nongated) begin
      wr_req  = cap;
      wr_word = {sof_pend_q, 1'b0, d};
    end else begin
      wr_req  = enable && stg_vld_q;
      wr_word = {stg_sof_q, !cap, stg_d_q};
    end

    seen_d     = enable;
    vs_prev_d  = vs;
    in_frame_d = enable && (sof || (in_frame_q && vs_act));
    act_d      = in_frame_q ? act_q : cfg_in;

    if (!enable)  sof_pend_d = 1'b0;
    else if (sof) sof_pend_d = 1'b1;
    else if (cap) sof_pend_d = 1'b0;
    else          sof_pend_d = sof_pend_q;

    stg_vld_d = ld_stage;

    if (sof)                       ovf_d = 1'b0;
    else if (wr_req && fifo_full)  ovf_d = 1'b1;
    else                           ovf_d = ovf_q;
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      vs_prev_q  <= 1'b0;
      in_frame_q <= 1'b0;
      act_q      <= '0;
      sof_pend_q <= 1'b0;
      stg_vld_q  <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      seen_q     <= seen_d;
      vs_prev_q  <= vs_prev_d;
      in_frame_q <= in_frame_d;
      act_q      <= act_d;
      sof_pend_q <= sof_pend_d;
      stg_vld_q  <= stg_vld_d;
      ovf_q      <= ovf_d;
    end
  end

  always_ff @(posedge pclk) begin
    if (ld_stage) begin
      stg_sof_q <= sof_pend_q;
      stg_d_q   <= d;
    end
  end

  assign overflow = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge pclk) disable iff (!rst_n)
    (ovf_q && !sof) |=> ovf_q); // R8
  AST_OVF_CLEAR: assert property (@(posedge pclk) disable iff (!rst_n)
    sof |=> !ovf_q); // R8
  AST_CFG_HELD: assert property (@(posedge pclk) disable iff (!rst_n)
    in_frame_q |=> $stable(act_q)); // R9
  AST_EOL_GATED_ONLY: assert property (@(posedge pclk) disable iff (!rst_n)
    (wr_req && wr_word[DW]) |-> !eff_cfg.nongated); // R7
  AST_NO_SOF_WHEN_OFF: assert property (@(posedge pclk) disable iff (!rst_n)
    !enable |=> !in_frame_q); // R10

endmodule

// File: rtl/csi_fifo.sv
module csi_fifo #(
  parameter int WW    = 22,
  parameter int DEPTH = 8
) (
  input  logic          pclk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [WW-1:0] wr_word,
  input  logic          rd_en,
  output logic          full,
  output logic          valid,
  output logic [WW-1:0] head
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd;

  always_comb begin
    full  = (cnt_q == CW'(DEPTH));
    valid = (cnt_q != '0);
    do_wr = wr_req && !full;
    do_rd = rd_en && valid;
    wp_d  = do_wr ? wp_q + AW'(1) : wp_q;
    rp_d  = do_rd ? rp_q + AW'(1) : rp_q;
    cnt_d = cnt_q + CW'(do_wr) - CW'(do_rd);
    head  = mem[rp_q];
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge pclk) begin
    if (do_wr) mem[wp_q] <= wr_word;
  end

  AST_COUNT_BOUND: assert property (@(posedge pclk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R11
  AST_FULL_HOLD: assert property (@(posedge pclk) disable iff (!rst_n)
    (full && !rd_en) |=> full); // R8
  AST_EMPTY_POP: assert property (@(posedge pclk) disable iff (!rst_n)
    (!valid && !wr_req) |=> !valid); // R11

endmodule

// File: rtl/csi_capture.sv
module csi_capture
  import csi_pkg::*;
#(
  parameter int DW    = 20,
  parameter int DEPTH = 8
) (
  input  logic          pclk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cfg_nongated,
  input  logic          cfg_hs_low,
  input  logic          cfg_vs_fall,
  input  logic          cfg_pclk_fall,
  input  logic          sen_vsync,
  input  logic          sen_hsync,
  input  logic [DW-1:0] sen_data,
  input  logic          rd_en,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eol,
  output logic          overflow
);

  localparam int WW = DW + 2;

  logic [1:0]    rst_sync_q;
  logic          srst_n;
  csi_cfg_t      cfg_in, eff_cfg;
  logic          s_vs, s_hs;
  logic [DW-1:0] s_d;
  logic          wr_req, fifo_full;
  logic [WW-1:0] wr_word, head;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  always_comb begin
    cfg_in.nongated  = cfg_nongated;
    cfg_in.hs_low    = cfg_hs_low;
    cfg_in.vs_fall   = cfg_vs_fall;
    cfg_in.pclk_fall = cfg_pclk_fall;
  end

  csi_sampler #(.DW(DW)) u_samp (
    .pclk(pclk), .rst_n(srst_n), .edge_fall(eff_cfg.pclk_fall),
    .vs_i(sen_vsync), .hs_i(sen_hsync), .d_i(sen_data),
    .vs_o(s_vs), .hs_o(s_hs), .d_o(s_d)
  );

  csi_framer #(.DW(DW)) u_frm (
    .pclk(pclk), .rst_n(srst_n), .enable(enable), .cfg_in(cfg_in),
    .vs(s_vs), .hs(s_hs), .d(s_d), .fifo_full(fifo_full),
    .eff_cfg(eff_cfg), .wr_req(wr_req), .wr_word(wr_word), .overflow(overflow)
  );

  csi_fifo #(.WW(WW), .DEPTH(DEPTH)) u_fifo (
    .pclk(pclk), .rst_n(srst_n), .wr_req(wr_req), .wr_word(wr_word),
    .rd_en(rd_en), .full(fifo_full), .valid(out_valid), .head(head)
  );

  assign out_sof  = head[WW-1];
  assign out_eol  = head[WW-2];
  assign out_data = head[DW-1:0];

endmodule

// File: tb/csi_capture_tb.sv
module csi_capture_tb;

  localparam int CLK_P = 10;

  logic        pclk = 1'b0;
  logic        rst_n, enable, rd_en;
  logic        cfg_nongated, cfg_hs_low, cfg_vs_fall, cfg_pclk_fall;
  logic        sen_vsync, sen_hsync;
  logic [19:0] sen_data;
  logic        out_valid, out_sof, out_eol, overflow;
  logic [19:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [21:0] exp_buf [32];
  int exp_n = 0;
  int got_n = 0;

  // stimulus {vsync, hsync, data}: gated frame, active-high syncs
  localparam logic [21:0] STIM [11] = '{
    {2'b01, 20'h00011}, {2'b00, 20'h00000}, {2'b10, 20'h00022},
    {2'b11, 20'hA0001}, {2'b11, 20'hA0002}, {2'b10, 20'h00033},
    {2'b11, 20'hB0001}, {2'b10, 20'h00000}, {2'b11, 20'hC0001},
    {2'b01, 20'hC0002}, {2'b00, 20'h00000}
  };
  // expected words {sof, eol, data}
  localparam logic [21:0] EXPT [4] = '{
    {2'b10, 20'hA0001}, {2'b01, 20'hA0002},
    {2'b01, 20'hB0001}, {2'b01, 20'hC0001}
  };

  always #(CLK_P/2) pclk = ~pclk;

  csi_capture u_dut (
    .pclk(pclk), .rst_n(rst_n), .enable(enable),
    .cfg_nongated(cfg_nongated), .cfg_hs_low(cfg_hs_low),
    .cfg_vs_fall(cfg_vs_fall), .cfg_pclk_fall(cfg_pclk_fall),
    .sen_vsync(sen_vsync), .sen_hsync(sen_hsync), .sen_data(sen_data),
    .rd_en(rd_en), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_exp();
    exp_n = 0;
    got_n = 0;
  endtask

  task automatic add_exp(input logic [21:0] w);
    exp_buf[exp_n] = w;
    exp_n++;
  endtask

  task automatic drv(input logic vs, input logic hs, input logic [19:0] d);
    @(posedge pclk);
    #2;
    sen_vsync = vs; sen_hsync = hs; sen_data = d;
  endtask

  // dx is stable at the falling edge, dy at the following rising edge
  task automatic drv2(input logic vs, input logic hs, input logic [19:0] dx, input logic [19:0] dy);
    @(posedge pclk);
    #2;
    sen_vsync = vs; sen_hsync = hs; sen_data = dx;
    #5;
    sen_data = dy;
  endtask

  task automatic idle(input logic vs, input logic hs, input int n);
    for (int i = 0; i < n; i++) drv(vs, hs, 20'h0);
  endtask

  // pop monitor: R6 R7 R11 word order and flags
  always @(negedge pclk) begin
    if (rst_n && rd_en && out_valid) begin
      if (got_n >= exp_n) chk("R11 unexpected word", {10'h0, out_sof, out_eol, out_data}, 32'hFFFFFFFF);
      else chk("R6/R7/R11 popped word", {10'h0, out_sof, out_eol, out_data}, {10'h0, exp_buf[got_n]});
      got_n++;
    end
  end

  initial begin
    repeat (100000) @(posedge pclk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 0; enable = 0; rd_en = 1;
    cfg_nongated = 0; cfg_hs_low = 0; cfg_vs_fall = 0; cfg_pclk_fall = 0;
    sen_vsync = 0; sen_hsync = 0; sen_data = '0;
    repeat (3) @(posedge pclk);
    #2 rst_n = 1;
    idle(0, 0, 3);
    @(negedge pclk);
    chk("R11 reset out_valid", {31'h0, out_valid}, 32'h0);
    chk("R8 reset overflow", {31'h0, overflow}, 32'h0);
    enable = 1;
    idle(0, 0, 3);

    // table: gated frame R1 R3 R6 R7
    clear_exp();
    for (int i = 0; i < 4; i++) add_exp(EXPT[i]);
    for (int i = 0; i < 11; i++) drv(STIM[i][21], STIM[i][20], STIM[i][19:0]);
    idle(0, 0, 5);
    chk("R1 gated word count", got_n, exp_n);

    // inverted sync polarities R3 R4
    cfg_vs_fall = 1; cfg_hs_low = 1;
    idle(1, 1, 3);
    clear_exp();
    for (int i = 0; i < 4; i++) add_exp(EXPT[i]);
    for (int i = 0; i < 11; i++) drv(~STIM[i][21], ~STIM[i][20], STIM[i][19:0]);
    idle(1, 1, 5);
    chk("R4 inverted polarity word count", got_n, exp_n);
    cfg_vs_fall = 0; cfg_hs_low = 0;
    idle(0, 0, 3);

    // non-gated R2 R7
    cfg_nongated = 1;
    idle(0, 0, 2);
    clear_exp();
    add_exp({2'b10, 20'h11111}); add_exp({2'b00, 20'h22222}); add_exp({2'b00, 20'h33333});
    drv(1, 0, 20'h0);
    drv(1, 0, 20'h11111);
    drv(1, 1, 20'h22222);
    drv(1, 0, 20'h33333);
    drv(0, 1, 20'h44444);
    idle(0, 0, 4);
    chk("R2 non-gated word count", got_n, exp_n);

    // falling-edge sampling R5
    cfg_pclk_fall = 1;
    drv2(0, 0, 20'h0, 20'h0);
    drv2(0, 0, 20'h0, 20'h0);
    clear_exp();
    add_exp({2'b10, 20'h0F00F}); add_exp({2'b00, 20'h0F0F0});
    drv2(1, 0, 20'h0, 20'h0);
    drv2(1, 0, 20'h0F00F, 20'hBAD00);
    drv2(1, 0, 20'h0F0F0, 20'hBAD01);
    drv2(0, 0, 20'h0, 20'h0);
    idle(0, 0, 4);
    chk("R5 falling-edge word count", got_n, exp_n);
    cfg_pclk_fall = 0;
    idle(0, 0, 2);

    // overflow R8 R11
    rd_en = 0;
    clear_exp();
    drv(1, 0, 20'h0);
    for (int i = 0; i < 10; i++) drv(1, 0, 20'h00100 + 20'(i));
    idle(0, 0, 3);
    @(negedge pclk);
    chk("R8 overflow set", {31'h0, overflow}, 32'h1);
    chk("R11 out_valid when full", {31'h0, out_valid}, 32'h1);
    for (int i = 0; i < 8; i++) add_exp({(i == 0), 1'b0, 20'h00100 + 20'(i)});
    rd_en = 1;
    idle(0, 0, 12);
    chk("R8 kept words count", got_n, exp_n);
    @(negedge pclk);
    chk("R8 overflow sticky", {31'h0, overflow}, 32'h1);
    cfg_nongated = 0;
    idle(0, 0, 2);
    drv(1, 0, 20'h0);
    idle(1, 0, 3);
    @(negedge pclk);
    chk("R8 overflow cleared at frame start", {31'h0, overflow}, 32'h0);
    idle(0, 0, 3);

    // mid-frame configuration change R9
    clear_exp();
    add_exp({2'b11, 20'hD0001}); add_exp({2'b01, 20'hD0002});
    drv(1, 0, 20'h0);
    drv(1, 1, 20'hD0001);
    drv(1, 0, 20'h0);
    cfg_nongated = 1;
    drv(1, 0, 20'hE0001);
    drv(1, 0, 20'hE0002);
    drv(1, 1, 20'hD0002);
    drv(1, 0, 20'h0);
    drv(0, 0, 20'h0);
    cfg_nongated = 0;
    idle(0, 0, 4);
    chk("R9 mid-frame cfg word count", got_n, exp_n);

    // discard before a valid frame start R10
    clear_exp();
    enable = 0;
    for (int i = 0; i < 3; i++) drv(1, 1, 20'h77777);
    enable = 1;
    for (int i = 0; i < 4; i++) drv(1, 1, 20'h66666);
    idle(1, 0, 3);
    @(negedge pclk);
    chk("R10 no words before frame start", got_n, 0);
    chk("R10 out_valid stays low", {31'h0, out_valid}, 32'h0);
    add_exp({2'b11, 20'h55555});
    drv(0, 0, 20'h0);
    drv(1, 0, 20'h0);
    drv(1, 1, 20'h55555);
    drv(1, 0, 20'h0);
    idle(0, 0, 4);
    chk("R10 capture after frame start", got_n, exp_n);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule